// File: doc/BRIEF.md
# Dual Bidirectional GPIO Port

This block gives a small controller two register-mapped general-purpose I/O ports: a full port of eight pins and a narrow port of four pins. Each pin has an output latch and a direction bit. A direction bit of 1 turns the pin's driver off, so the pin is a high-impedance input. A direction bit of 0 turns the driver on, and the pin drives the latch value. The block presents a per-pin output enable and a per-pin output value to tri-state pads.

The core writes a port's latch through a write strobe and an 8-bit data word. It sets directions with a separate load strobe that carries an 8-bit word and a 1-bit port select. The direction registers cannot be read back. A read of a port returns the pin levels after a two-flop synchronizer. It never returns the latch, so a pin that drives high while something outside holds it low reads as 0.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset, every output enable is 0 (all pins are high-impedance inputs) and every output value is 0.
- R2: Each pin's output enable is the inverse of its direction bit, and its output value is its latch bit.
- R3: With the direction load strobe high, select 0 loads the full port's eight direction bits from the load word, and select 1 loads the narrow port's direction bits from load word bits 3:0. The new directions take effect after that clock edge. The other port's directions do not change.
- R4: Load word bits 7:4 have no effect on the narrow port's directions.
- R5: A port read returns the pin levels as they were two clock edges earlier. This holds whatever the direction and latch settings are, so a driven-high pin held low reads as 0.
- R6: Bits 7:4 of the narrow port's read data are always 0.
- R7: A latch write takes effect after the clock edge, even while the pin is an input. A latch keeps its value until it is written again.
- R8: Bits 7:4 of a narrow-port write word have no effect on its outputs.
- R9: Each pin's direction is set on its own, so a single 0 bit in the load word enables exactly that pin's driver.
- R10: A latch write and a direction load in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_wr_en | input | 1 | Full-port latch write strobe |
| wide_wr_data | input | 8 | Full-port latch write word |
| wide_rd_data | output | 8 | Full-port synchronized pin levels |
| narrow_wr_en | input | 1 | Narrow-port latch write strobe |
| narrow_wr_data | input | 8 | Narrow-port latch write word (bits 3:0 used) |
| narrow_rd_data | output | 8 | Narrow-port pin levels, bits 7:4 zero |
| dir_load | input | 1 | Direction load strobe |
| dir_sel | input | 1 | Direction target: 0 full port, 1 narrow port |
| dir_data | input | 8 | Direction load word (1 = input) |
| wide_pad_in | input | 8 | Full-port pin levels from pads |
| wide_pad_oe | output | 8 | Full-port driver enables |
| wide_pad_out | output | 8 | Full-port driven values |
| narrow_pad_in | input | 4 | Narrow-port pin levels from pads |
| narrow_pad_oe | output | 4 | Narrow-port driver enables |
| narrow_pad_out | output | 4 | Narrow-port driven values |

## Verification
The bench sweeps every direction word and every latch word through both ports. This catches a design that reads back the latch instead of the pins: it would return the driven value while the pin is held at the opposite level. It also catches a select that is decoded the wrong way or that lets one load reach both ports, because the untouched port's enables would then move. A sweep that loads a single 0 bit at each position finds enables that are crossed or shifted. A write made while the pin is an input, then exposed by switching the pin to output, finds a latch that gates writes on direction. Walking the pin inputs finds a read path with the wrong delay or with nonzero upper bits on the narrow port.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_W       = 8;
  localparam int unsigned WIDE_PINS   = 8;
  localparam int unsigned NARROW_PINS = 4;

  typedef enum logic {
    PORT_WIDE   = 1'b0,
    PORT_NARROW = 1'b1
  } port_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pin_async;
      stage2_q <= stage1_q;
    end
  end

  // cycles since reset, saturating at 2, used by the delay check only
  always_ff @(posedge clk) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assign pin_sync = stage2_q;

  p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (pin_sync == $past(pin_async, 2)))
    else $error("R5: synchronized pins do not lag pad inputs by two edges");
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int unsigned         PINS    = 8,
  parameter int unsigned         BUS_W   = 8,
  parameter gpio_pkg::port_sel_e PORT_ID = gpio_pkg::PORT_WIDE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             dir_load,
  input  logic             dir_sel,
  input  logic [BUS_W-1:0] dir_data,
  input  logic [PINS-1:0]  pin_sync,
  output logic [BUS_W-1:0] rd_data,
  output logic [PINS-1:0]  pad_oe,
  output logic [PINS-1:0]  pad_out,
  output logic             dir_hit
);
  localparam int unsigned GAP_W = BUS_W - PINS;

  logic [PINS-1:0] latch_q;
  logic [PINS-1:0] dir_q;
  logic            write_hit;

  // pad a pin vector to the bus width with zeros above the pins
  function automatic logic [BUS_W-1:0] widen(input logic [PINS-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[PINS-1:0] = v;
    return r;
  endfunction

  assign write_hit = wr_en;
  assign dir_hit   = dir_load && (dir_sel == PORT_ID);

  generate
    if (GAP_W > 0) begin : g_gap
      logic unused_gap_bits;
      assign unused_gap_bits = ^{wr_data[BUS_W-1:PINS], dir_data[BUS_W-1:PINS]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         latch_q <= '0;
    else if (write_hit) latch_q <= wr_data[PINS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       dir_q <= '1;
    else if (dir_hit) dir_q <= dir_data[PINS-1:0];
  end

  assign pad_oe  = ~dir_q;
  assign pad_out = latch_q;
  assign rd_data = widen(pin_sync);

  p_latch_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    write_hit |=> (pad_out == $past(wr_data[PINS-1:0])))
    else $error("R7: latch write not reflected on pad_out");

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !write_hit |=> $stable(pad_out))
    else $error("R7: pad_out changed without a write");

  p_dir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_hit |=> (pad_oe == ~$past(dir_data[PINS-1:0])))
    else $error("R3: direction load not reflected on pad_oe");

  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_hit |=> $stable(pad_oe))
    else $error("R3: pad_oe changed without a load for this port");
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int unsigned BUS_W       = gpio_pkg::BUS_W,
  parameter int unsigned WIDE_PINS   = gpio_pkg::WIDE_PINS,
  parameter int unsigned NARROW_PINS = gpio_pkg::NARROW_PINS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wide_wr_en,
  input  logic [BUS_W-1:0]       wide_wr_data,
  output logic [BUS_W-1:0]       wide_rd_data,
  input  logic                   narrow_wr_en,
  input  logic [BUS_W-1:0]       narrow_wr_data,
  output logic [BUS_W-1:0]       narrow_rd_data,
  input  logic                   dir_load,
  input  logic                   dir_sel,
  input  logic [BUS_W-1:0]       dir_data,
  input  logic [WIDE_PINS-1:0]   wide_pad_in,
  output logic [WIDE_PINS-1:0]   wide_pad_oe,
  output logic [WIDE_PINS-1:0]   wide_pad_out,
  input  logic [NARROW_PINS-1:0] narrow_pad_in,
  output logic [NARROW_PINS-1:0] narrow_pad_oe,
  output logic [NARROW_PINS-1:0] narrow_pad_out
);
  logic [WIDE_PINS-1:0]   wide_sync;
  logic [NARROW_PINS-1:0] narrow_sync;
  logic                   wide_dir_hit;
  logic                   narrow_dir_hit;

  gpio_in_sync #(.W(WIDE_PINS)) i_wide_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(wide_pad_in), .pin_sync(wide_sync)
  );

  gpio_in_sync #(.W(NARROW_PINS)) i_narrow_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(narrow_pad_in), .pin_sync(narrow_sync)
  );

  gpio_port_slice #(
    .PINS(WIDE_PINS), .BUS_W(BUS_W), .PORT_ID(gpio_pkg::PORT_WIDE)
  ) i_wide_slice (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wide_wr_en), .wr_data(wide_wr_data),
    .dir_load(dir_load), .dir_sel(dir_sel), .dir_data(dir_data),
    .pin_sync(wide_sync), .rd_data(wide_rd_data),
    .pad_oe(wide_pad_oe), .pad_out(wide_pad_out), .dir_hit(wide_dir_hit)
  );

  gpio_port_slice #(
    .PINS(NARROW_PINS), .BUS_W(BUS_W), .PORT_ID(gpio_pkg::PORT_NARROW)
  ) i_narrow_slice (
    .clk(clk), .rst_n(rst_n),
    .wr_en(narrow_wr_en), .wr_data(narrow_wr_data),
    .dir_load(dir_load), .dir_sel(dir_sel), .dir_data(dir_data),
    .pin_sync(narrow_sync), .rd_data(narrow_rd_data),
    .pad_oe(narrow_pad_oe), .pad_out(narrow_pad_out), .dir_hit(narrow_dir_hit)
  );

  p_reset_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wide_pad_oe == '0 && narrow_pad_oe == '0))
    else $error("R1: a driver is enabled straight out of reset");

  p_reset_out_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wide_pad_out == '0 && narrow_pad_out == '0))
    else $error("R1: output latches nonzero straight out of reset");

  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_load |-> ($countones({wide_dir_hit, narrow_dir_hit}) == 1))
    else $error("R3: a direction load must reach exactly one port");
endmodule

// File: tb/test_gpio_dual_port.sv
module test_gpio_dual_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wide_wr_en, narrow_wr_en, dir_load, dir_sel;
  logic [7:0] wide_wr_data, narrow_wr_data, dir_data;
  logic [7:0] wide_rd_data, narrow_rd_data;
  logic [7:0] wide_pad_in, wide_pad_oe, wide_pad_out;
  logic [3:0] narrow_pad_in, narrow_pad_oe, narrow_pad_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_dual_port i_gpio_dual_port (
    .clk(clk), .rst_n(rst_n),
    .wide_wr_en(wide_wr_en), .wide_wr_data(wide_wr_data), .wide_rd_data(wide_rd_data),
    .narrow_wr_en(narrow_wr_en), .narrow_wr_data(narrow_wr_data), .narrow_rd_data(narrow_rd_data),
    .dir_load(dir_load), .dir_sel(dir_sel), .dir_data(dir_data),
    .wide_pad_in(wide_pad_in), .wide_pad_oe(wide_pad_oe), .wide_pad_out(wide_pad_out),
    .narrow_pad_in(narrow_pad_in), .narrow_pad_oe(narrow_pad_oe), .narrow_pad_out(narrow_pad_out)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic load_dir(input logic sel, input logic [7:0] val);
    dir_sel = sel; dir_data = val; dir_load = 1'b1;
    step();
    dir_load = 1'b0;
  endtask

  task automatic write_wide(input logic [7:0] val);
    wide_wr_data = val; wide_wr_en = 1'b1;
    step();
    wide_wr_en = 1'b0;
  endtask

  task automatic write_narrow(input logic [7:0] val);
    narrow_wr_data = val; narrow_wr_en = 1'b1;
    step();
    narrow_wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [7:0] wide_oe_before;
    rst_n = 1'b0;
    wide_wr_en = 0; narrow_wr_en = 0; dir_load = 0; dir_sel = 0;
    wide_wr_data = 0; narrow_wr_data = 0; dir_data = 0;
    wide_pad_in = 0; narrow_pad_in = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 wide oe", wide_pad_oe, 8'h00);
    chk("R1 narrow oe", {4'h0, narrow_pad_oe}, 8'h00);
    chk("R1 wide out", wide_pad_out, 8'h00);
    chk("R1 narrow out", {4'h0, narrow_pad_out}, 8'h00);

    // R3 R2 full-port direction sweep; narrow port untouched
    for (int v = 0; v < 256; v++) begin
      load_dir(1'b0, 8'(v));
      chk("R3 R2 wide oe", wide_pad_oe, ~8'(v));
      chk("R3 narrow oe untouched", {4'h0, narrow_pad_oe}, 8'h00);
    end
    // R3 R4 narrow sweep; full port keeps its last value
    wide_oe_before = wide_pad_oe;
    for (int v = 0; v < 256; v++) begin
      load_dir(1'b1, 8'(v));
      chk("R3 R4 narrow oe", {4'h0, narrow_pad_oe}, {4'h0, ~4'(v)});
      chk("R3 wide oe untouched", wide_pad_oe, wide_oe_before);
    end

    // R9 single driver enabled per position
    for (int i = 0; i < 8; i++) begin
      load_dir(1'b0, ~(8'h01 << i));
      chk("R9 wide single pin", wide_pad_oe, 8'h01 << i);
    end
    for (int i = 0; i < 4; i++) begin
      load_dir(1'b1, ~(8'h01 << i));
      chk("R9 narrow single pin", {4'h0, narrow_pad_oe}, 8'h01 << i);
    end

    // R7 write while input, then expose by switching to output
    load_dir(1'b0, 8'hFF);
    load_dir(1'b1, 8'hFF);
    write_wide(8'hA5);
    write_narrow(8'h0C);
    chk("R7 wide latch while input", wide_pad_out, 8'hA5);
    load_dir(1'b0, 8'h00);
    load_dir(1'b1, 8'h00);
    chk("R7 wide exposed oe", wide_pad_oe, 8'hFF);
    chk("R7 wide exposed out", wide_pad_out, 8'hA5);
    chk("R7 narrow exposed out", {4'h0, narrow_pad_out}, 8'h0C);
    repeat (5) step();
    chk("R7 wide hold", wide_pad_out, 8'hA5);
    chk("R7 narrow hold", {4'h0, narrow_pad_out}, 8'h0C);

    // R2 R8 latch sweep on both ports
    for (int v = 0; v < 256; v++) begin
      write_wide(8'(v));
      write_narrow(8'(v));
      chk("R2 wide out", wide_pad_out, 8'(v));
      chk("R8 narrow out", {4'h0, narrow_pad_out}, {4'h0, 4'(v)});
    end

    // R5 read returns pins, drivers fighting with the opposite value
    for (int v = 0; v < 256; v++) begin
      write_wide(~8'(v));
      wide_pad_in = 8'(v);
      step();
      step();
      chk("R5 wide read pins", wide_rd_data, 8'(v));
    end
    // R5 one edge is not enough
    wide_pad_in = 8'h00;
    repeat (2) step();
    wide_pad_in = 8'h3C;
    step();
    chk("R5 wide one-edge lag", wide_rd_data, 8'h00);
    step();
    chk("R5 wide two-edge", wide_rd_data, 8'h3C);
    // R5 R6 narrow reads, with inputs too
    load_dir(1'b1, 8'h0F);
    for (int v = 0; v < 16; v++) begin
      narrow_pad_in = 4'(v);
      step();
      step();
      chk("R5 R6 narrow read", narrow_rd_data, {4'h0, 4'(v)});
    end

    // R10 write and direction load in the same cycle
    wide_wr_data = 8'h5A; wide_wr_en = 1'b1;
    dir_sel = 1'b0; dir_data = 8'hF0; dir_load = 1'b1;
    step();
    wide_wr_en = 1'b0; dir_load = 1'b0;
    chk("R10 wide out", wide_pad_out, 8'h5A);
    chk("R10 wide oe", wide_pad_oe, 8'h0F);

    finished = 1'b1;
    summary();
  end
endmodule